// File: doc/BRIEF.md
# Multiply Unit with Signed High-Byte Correction

This block is the multiply stage of a small processor datapath. One operand comes from the working register and the other from the instruction word. Every operation starts with an unsigned 8 x 8 multiply. The 16-bit result goes into a product register pair: one register holds the upper byte and the other holds the lower byte. An unsigned request finishes in one cycle.

A signed request runs the same unsigned multiply. A short sequencer then corrects the upper byte. It takes one test step and one subtract step for each operand, in a fixed order, and then a completion step. Signed results therefore always take a fixed six cycles, whatever the operand signs are.

A status-flag bus passes through the block unchanged. The multiply never alters the datapath's flags. A start strobe with a signed/unsigned select launches an operation, and a busy/done pair reports progress.

Top module: `mulsc_unit`

## Requirements
- R1: An unsigned start accepted while idle loads the unsigned product of opa_i and opb_i. Product bits 15..8 appear on prod_hi_o and bits 7..0 on prod_lo_o.
- R2: An unsigned operation raises done_o after the first rising edge following the start cycle. busy_o stays low throughout.
- R3: A signed operation ends with the two's-complement product of the two operands on the product pair. It is formed by subtracting, modulo 256, opa from the upper byte when opb bit 7 is set, and then opb when opa bit 7 is set.
- R4: A signed operation raises busy_o after the start edge and keeps it high for five cycles. done_o rises together with the fall of busy_o, six rising edges after the start cycle.
- R5: When an operand's sign bit (bit 7) is clear, its subtract step leaves the upper byte unchanged. The latency stays at six cycles.
- R6: A start pulse that arrives while busy_o is high is ignored. The running result and its timing are unchanged.
- R7: done_o is a single-cycle pulse. Between operations the product pair holds its value until the next accepted start.
- R8: Operands are captured at an accepted start. Changes on opa_i and opb_i during a signed sequence do not affect the result.
- R9: flags_o equals flags_i in every cycle, including during and after any multiply.
- R10: An active-low asynchronous reset clears the product pair, busy_o and done_o at once, and returns the sequencer to idle. Release takes effect through a two-stage synchroniser.
- R11: The intermediate values in a signed sequence are visible in order. After the start edge the pair shows the raw unsigned product. After the third edge the upper byte already has the opb-sign correction applied and the lower byte is still raw.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| signed_i | input | 1 | 1 selects signed mode, 0 selects unsigned |
| opa_i | input | 8 | Working-register operand |
| opb_i | input | 8 | Instruction operand |
| flags_i | input | 8 | Status flags in |
| prod_hi_o | output | 8 | Product upper byte |
| prod_lo_o | output | 8 | Product lower byte |
| busy_o | output | 1 | Signed sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| flags_o | output | 8 | Status flags out, equal to flags_i |

## Verification
The stimulus is driven on falling edges, and every output is sampled at a falling edge. The bench then counts the rising edges between start and check. An unsigned result and its done pulse are due one edge after the start cycle. A signed run is sampled after edge one for the raw product, after edge three for the first correction, after edge five for busy still high with done low, and after edge six for the final product with done high. The cycle after that must show done low with the product unchanged. The flag bus is compared on every sampled cycle. Operand changes, extra starts during busy and a mid-sequence reset are injected at fixed edges, so that each expected value stays tied to one known cycle.

// File: rtl/mulsc_pkg.sv
package mulsc_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_TSTB  = 3'd1,
    SQ_SUBB  = 3'd2,
    SQ_TSTA  = 3'd3,
    SQ_SUBA  = 3'd4,
    SQ_FIN   = 3'd5
  } sq_state_e;

  // which latched operand a correction step removes from the upper byte
  typedef enum logic {
    CORR_OPA = 1'b0,
    CORR_OPB = 1'b1
  } corr_sel_e;

endpackage

// File: rtl/mulsc_rst_sync.sv
module mulsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/mulsc_core.sv
module mulsc_core #(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0]   mcand_i,
  input  logic [OP_W-1:0]   mplier_i,
  output logic [2*OP_W-1:0] prod_o
);

  localparam int PROD_W = 2 * OP_W;

  logic [PROD_W-1:0] part [OP_W];

  // one shifted partial product per multiplier bit
  for (genvar i = 0; i < OP_W; i++) begin : g_part
    assign part[i] = mplier_i[i] ? (PROD_W'(mcand_i) << i) : '0;
  end

  always_comb begin
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < OP_W; i++) begin
      acc = acc + part[i];
    end
    prod_o = acc;
  end

endmodule

// File: rtl/mulsc_seq.sv
module mulsc_seq
  import mulsc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      signed_i,
  input  logic      sign_a_i,
  input  logic      sign_b_i,
  output logic      accept_o,
  output logic      sub_en_o,
  output corr_sel_e sub_sel_o,
  output logic      busy_o,
  output logic      done_o
);

  sq_state_e state_q, state_d;
  logic      neg_q, neg_d, neg_en;
  logic      done_q, done_d;

  assign accept_o = start_i && (state_q == SQ_IDLE);

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE: if (accept_o && signed_i) state_d = SQ_TSTB;
      SQ_TSTB: state_d = SQ_SUBB;
      SQ_SUBB: state_d = SQ_TSTA;
      SQ_TSTA: state_d = SQ_SUBA;
      SQ_SUBA: state_d = SQ_FIN;
      SQ_FIN:  state_d = SQ_IDLE;
      default: state_d = SQ_IDLE;
    endcase
  end

  // sign test result, captured in the test states only
  always_comb begin
    neg_en = 1'b0;
    neg_d  = neg_q;
    if (state_q == SQ_TSTB) begin
      neg_en = 1'b1;
      neg_d  = sign_b_i;
    end else if (state_q == SQ_TSTA) begin
      neg_en = 1'b1;
      neg_d  = sign_a_i;
    end
  end

  assign done_d = (accept_o && !signed_i) || (state_q == SQ_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_q <= 1'b0;
    end else if (neg_en) begin
      neg_q <= neg_d;
    end
  end

  // subtract only when the preceding test found a negative operand
  assign sub_en_o  = neg_q && ((state_q == SQ_SUBB) || (state_q == SQ_SUBA));
  assign sub_sel_o = (state_q == SQ_SUBB) ? CORR_OPA : CORR_OPB;
  assign busy_o    = (state_q != SQ_IDLE);
  assign done_o    = done_q;

endmodule

// File: rtl/mulsc_unit.sv
module mulsc_unit
  import mulsc_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int FLAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              signed_i,
  input  logic [OP_W-1:0]   opa_i,
  input  logic [OP_W-1:0]   opb_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic [OP_W-1:0]   prod_hi_o,
  output logic [OP_W-1:0]   prod_lo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [FLAG_W-1:0] flags_o
);

  localparam int PROD_W = 2 * OP_W;

  logic              rst_n_int;
  logic              accept;
  logic              sub_en;
  corr_sel_e         sub_sel;
  logic [PROD_W-1:0] raw_prod;
  logic [OP_W-1:0]   opa_q, opb_q;
  logic [OP_W-1:0]   hi_q, hi_d, lo_q, lo_d;
  logic              hi_en, lo_en;
  logic [OP_W-1:0]   corr_val;

  mulsc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  mulsc_core #(.OP_W(OP_W)) i_core (
    .mcand_i  (opa_i),
    .mplier_i (opb_i),
    .prod_o   (raw_prod)
  );

  mulsc_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start_i   (start_i),
    .signed_i  (signed_i),
    .sign_a_i  (opa_q[OP_W-1]),
    .sign_b_i  (opb_q[OP_W-1]),
    .accept_o  (accept),
    .sub_en_o  (sub_en),
    .sub_sel_o (sub_sel),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  // operand capture at accepted start
  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      opa_q <= '0;
      opb_q <= '0;
    end else if (accept) begin
      opa_q <= opa_i;
      opb_q <= opb_i;
    end
  end

  assign corr_val = (sub_sel == CORR_OPA) ? opa_q : opb_q;

  // product pair next-state with explicit enables
  always_comb begin
    hi_en = accept || sub_en;
    lo_en = accept;
    hi_d  = hi_q;
    lo_d  = lo_q;
    if (accept) begin
      hi_d = raw_prod[PROD_W-1:OP_W];
      lo_d = raw_prod[OP_W-1:0];
    end else if (sub_en) begin
      hi_d = hi_q - corr_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      hi_q <= '0;
    end else if (hi_en) begin
      hi_q <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      lo_q <= '0;
    end else if (lo_en) begin
      lo_q <= lo_d;
    end
  end

  assign prod_hi_o = hi_q;
  assign prod_lo_o = lo_q;
  assign flags_o   = flags_i;

endmodule

// File: rtl/mulsc_chk.sv
module mulsc_chk #(
  parameter int OP_W = 8
) (
  input logic            clk,
  input logic            rst_ok,
  input logic            start_i,
  input logic            signed_i,
  input logic [OP_W-1:0] opa_i,
  input logic [OP_W-1:0] opb_i,
  input logic [OP_W-1:0] prod_hi_o,
  input logic [OP_W-1:0] prod_lo_o,
  input logic            busy_o,
  input logic            done_o
);

  localparam int PROD_W = 2 * OP_W;

  logic              take;
  logic [2:0]        cnt_q;
  logic [PROD_W-1:0] exp_u_q, exp_s_q;
  logic [PROD_W-1:0] exp_u, exp_s;
  logic [PROD_W-1:0] prod;

  assign take  = start_i && !busy_o;
  assign prod  = {prod_hi_o, prod_lo_o};
  assign exp_u = PROD_W'(opa_i) * PROD_W'(opb_i);
  assign exp_s = PROD_W'($signed({{OP_W{opa_i[OP_W-1]}}, opa_i}) *
                         $signed({{OP_W{opb_i[OP_W-1]}}, opb_i}));

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      cnt_q   <= '0;
      exp_u_q <= '0;
      exp_s_q <= '0;
    end else begin
      if (take) begin
        exp_u_q <= exp_u;
        exp_s_q <= exp_s;
      end
      if (take && signed_i)               cnt_q <= 3'd1;
      else if (cnt_q != 0 && cnt_q != 6)  cnt_q <= cnt_q + 3'd1;
      else                                cnt_q <= '0;
    end
  end

  a_r1_unsigned_product: assert property (@(posedge clk) disable iff (!rst_ok)
    (take && !signed_i) |=> (prod == exp_u_q));

  a_r2_unsigned_done: assert property (@(posedge clk) disable iff (!rst_ok)
    (take && !signed_i) |=> (done_o && !busy_o));

  a_r3_signed_result: assert property (@(posedge clk) disable iff (!rst_ok)
    (cnt_q == 3'd6) |-> (prod == exp_s_q));

  a_r4_busy_window: assert property (@(posedge clk) disable iff (!rst_ok)
    (cnt_q != 3'd0 && cnt_q != 3'd6) |-> (busy_o && !done_o));

  a_r4_signed_done: assert property (@(posedge clk) disable iff (!rst_ok)
    (cnt_q == 3'd6) |-> (done_o && !busy_o));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_ok)
    done_o |=> !done_o);

  a_r7_product_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    (!busy_o && !start_i) |=> $stable(prod));

endmodule

bind mulsc_unit mulsc_chk #(.OP_W(OP_W)) i_chk (
  .clk       (clk),
  .rst_ok    (rst_n_int),
  .start_i   (start_i),
  .signed_i  (signed_i),
  .opa_i     (opa_i),
  .opb_i     (opb_i),
  .prod_hi_o (prod_hi_o),
  .prod_lo_o (prod_lo_o),
  .busy_o    (busy_o),
  .done_o    (done_o)
);

// File: tb/test_mulsc_unit.sv
module test_mulsc_unit;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, signed_i;
  logic [7:0] opa_i, opb_i, flags_i;
  logic [7:0] prod_hi_o, prod_lo_o, flags_o;
  logic       busy_o, done_o;

  int  n_chk = 0;
  int  n_err = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulsc_unit i_mulsc_unit (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
    .opa_i(opa_i), .opb_i(opb_i), .flags_i(flags_i),
    .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o),
    .busy_o(busy_o), .done_o(done_o), .flags_o(flags_o)
  );

  function automatic logic [15:0] f_uns(input logic [7:0] a, b);
    return 16'(a) * 16'(b);
  endfunction

  function automatic logic [15:0] f_sgn(input logic [7:0] a, b);
    logic signed [15:0] sa, sb;
    sa = $signed({{8{a[7]}}, a});
    sb = $signed({{8{b[7]}}, b});
    return 16'(sa * sb);
  endfunction

  function automatic logic [15:0] f_mid(input logic [7:0] a, b);
    logic [15:0] r;
    r = f_uns(a, b);
    r[15:8] = r[15:8] - (b[7] ? a : 8'd0);
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // advance to the next falling edge, checking the flag bypass first
  task automatic tick();
    @(negedge clk);
    chk("R9 flags", {24'd0, flags_o}, {24'd0, flags_i});
    flags_i = 8'($urandom);
  endtask

  task automatic run_uns(input logic [7:0] a, b);
    logic [15:0] held;
    start_i = 1'b1; signed_i = 1'b0; opa_i = a; opb_i = b;
    tick();
    start_i = 1'b0;
    chk("R1 unsigned product", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_uns(a, b)});
    chk("R2 done after one edge", {30'd0, done_o, busy_o}, 32'd2);
    held = {prod_hi_o, prod_lo_o};
    opa_i = 8'($urandom); opb_i = 8'($urandom);
    tick();
    chk("R7 done pulse ends", {31'd0, done_o}, 32'd0);
    chk("R7 product holds", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, held});
  endtask

  task automatic run_sgn(input logic [7:0] a, b, input bit perturb, input bit poke);
    start_i = 1'b1; signed_i = 1'b1; opa_i = a; opb_i = b;
    tick();                                   // after edge 1
    start_i = 1'b0;
    chk("R11 raw product first", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_uns(a, b)});
    chk("R4 busy after start", {30'd0, busy_o, done_o}, 32'd2);
    if (perturb) begin
      opa_i = 8'($urandom); opb_i = 8'($urandom); signed_i = 1'($urandom);
    end
    tick();                                   // after edge 2
    if (poke) begin
      start_i = 1'b1; signed_i = 1'b0;        // R6: must be ignored
      opa_i = 8'($urandom); opb_i = 8'($urandom);
    end
    tick();                                   // after edge 3
    start_i = 1'b0;
    chk("R11 first correction", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_mid(a, b)});
    tick();                                   // after edge 4
    tick();                                   // after edge 5
    chk("R4 still busy at edge 5", {30'd0, busy_o, done_o}, 32'd2);
    tick();                                   // after edge 6
    chk("R3 signed result", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_sgn(a, b)});
    chk("R4 R5 done at edge 6", {30'd0, busy_o, done_o}, 32'd1);
    if (perturb) chk("R8 operands latched", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_sgn(a, b)});
    if (poke)    chk("R6 busy start ignored", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_sgn(a, b)});
    tick();
    chk("R7 signed done pulse ends", {30'd0, busy_o, done_o}, 32'd0);
    chk("R7 signed product holds", {16'd0, prod_hi_o, prod_lo_o}, {16'd0, f_sgn(a, b)});
  endtask

  initial begin
    void'($urandom(32'h5eed_0c1e));
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0;
    opa_i = 8'h00; opb_i = 8'h00; flags_i = 8'hA5;
    repeat (3) tick();
    chk("R10 reset product", {16'd0, prod_hi_o, prod_lo_o}, 32'd0);
    chk("R10 reset busy done", {30'd0, busy_o, done_o}, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();

    // directed corners
    run_uns(8'hFF, 8'hFF);
    run_uns(8'h00, 8'h9C);
    run_uns(8'h80, 8'h02);
    run_sgn(8'h80, 8'h80, 1'b0, 1'b0);
    run_sgn(8'hFF, 8'hFF, 1'b0, 1'b0);
    run_sgn(8'h7F, 8'h80, 1'b0, 1'b0);
    run_sgn(8'h80, 8'h7F, 1'b0, 1'b0);
    run_sgn(8'h35, 8'h12, 1'b0, 1'b0);        // R5: both signs clear
    run_sgn(8'h00, 8'hFF, 1'b1, 1'b1);

    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [7:0] a, b;
      a = 8'($urandom); b = 8'($urandom);
      if (($urandom % 2) == 0) run_uns(a, b);
      else run_sgn(a, b, 1'($urandom), 1'($urandom));
    end

    // reset in the middle of a signed sequence
    start_i = 1'b1; signed_i = 1'b1; opa_i = 8'hC3; opb_i = 8'h9A;
    tick();
    start_i = 1'b0;
    tick();
    #1 rst_n = 1'b0;
    #1;
    chk("R10 async clear product", {16'd0, prod_hi_o, prod_lo_o}, 32'd0);
    chk("R10 async clear busy done", {30'd0, busy_o, done_o}, 32'd0);
    tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R10 idle after release", {30'd0, busy_o, done_o}, 32'd0);
    run_sgn(8'hC3, 8'h9A, 1'b0, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule